// File: doc/BRIEF.md
# Serial Flash Read Responder

This block answers the read path of a serial configuration flash on a four-wire slave interface. The pins are an active-low chip select, a serial clock, a serial data input and a serial data output. The output has a separate enable line, so a pad or the bench can make a tri-state from it. After chip select falls, the master shifts in a command byte and a three-byte address, MSB first. The block then streams bytes from an internal byte array. After each byte the address moves up by one, and it wraps to zero past the top of the array. Two commands are decoded: a plain read, and a fast read that expects one dummy byte before the data.

The whole block runs on one system clock. The serial pins pass through a synchroniser, and the serial clock edges are found by comparing samples of it, so the serial clock must be several times slower than the system clock. The array is a block-RAM style memory with its own parameterised address width. Of the 24 address bits shifted in, only the low ones are kept, and the rest are don't-care. A mode pin selects LSB-first output, for images stored in raw programming order. A busy input stands in for a write or erase in progress; a read command that arrives while it is high is dropped. A backdoor write port fills the array.

Top module: `serial_flash_reader`

## Requirements
- R1: After reset, `sdo_oe` and `sdo` are 0.
- R2: Command 0x03 followed by a 24-bit address (all bits MSB first, sampled on rising serial clock edges) returns the byte at that address. Its first bit is driven on the serial clock falling edge that follows the last address bit.
- R3: Data bits change only after a falling edge of the serial clock and hold steady across the following rising edge. `sdo_oe` goes to 1 on the first data falling edge.
- R4: After each eight data bits, the next byte comes from the address one higher, with no gap.
- R5: After address 2^MEM_AW-1, the stream continues at address 0.
- R6: Command 0x0B takes eight extra dummy clocks after the address, then streams data as in R2.
- R7: With `raw_order`=1, bit 0 of each byte is sent first and bit 7 last. With `raw_order`=0, bit 7 is sent first.
- R8: Address bits 23 down to MEM_AW have no effect on which byte is read.
- R9: If `busy` is 1 when the eighth command bit is sampled, the read is not executed and `sdo_oe` stays 0 until chip select rises.
- R10: Any command code other than 0x03 or 0x0B keeps `sdo_oe` at 0 until chip select rises.
- R11: Raising `cs_n` ends the transfer at any bit. `sdo_oe` is 0 within four system clocks, and the next selection starts with a fresh command.
- R12: `sdo_oe` is 0 during the command, address and dummy phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial command and address input |
| busy | input | 1 | Write or erase in progress; blocks read commands |
| raw_order | input | 1 | 1 = LSB-first data output |
| bd_we | input | 1 | Backdoor write enable |
| bd_addr | input | MEM_AW | Backdoor write address |
| bd_data | input | 8 | Backdoor write data |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |

## Verification
A serial clock edge takes two synchroniser flops and one edge compare to reach the block. The output flop adds one more, so a data bit or an enable change is visible about three system clocks after the falling edge. A rise of chip select clears `sdo_oe` within the same three clocks. The bench holds each half of the serial clock for eight system clocks. It samples `sdo` and `sdo_oe` on the last falling system clock edge before raising the serial clock, well after the value has settled. It checks the abort case four clocks after chip select rises. For the steadiness check of R3, it samples a data bit once before the rising serial edge and once late in the high half, and compares the two samples.

// File: rtl/serflash_pkg.sv
package serflash_pkg;

  localparam int ADDR_BITS = 24;
  localparam int CMD_BITS  = 8;

  localparam logic [CMD_BITS-1:0] OP_READ = 8'h03;
  localparam logic [CMD_BITS-1:0] OP_FAST = 8'h0B;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_IGNORE
  } phase_t;

endpackage

// File: rtl/sfr_pin_sync.sv
module sfr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s
);

  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] sck_p;
  logic [STAGES-1:0] sdi_p;
  logic              sck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p     <= '1;
      sck_p    <= '0;
      sdi_p    <= '0;
      sck_last <= 1'b0;
    end else begin
      cs_p     <= {cs_p[STAGES-2:0], cs_n};
      sck_p    <= {sck_p[STAGES-2:0], sck};
      sdi_p    <= {sdi_p[STAGES-2:0], sdi};
      sck_last <= sck_p[STAGES-1];
    end
  end

  assign sel      = ~cs_p[STAGES-1];
  assign sck_rise = sck_p[STAGES-1] & ~sck_last;
  assign sck_fall = ~sck_p[STAGES-1] & sck_last;
  assign sdi_s    = sdi_p[STAGES-1];

endmodule

// File: rtl/sfr_mem.sv
module sfr_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= store[raddr];
    end
  end

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import serflash_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdi,
  input  logic              busy,
  output logic              rd_en,
  output logic [MEM_AW-1:0] rd_addr,
  output logic              drive,
  output logic [2:0]        bit_idx,
  output phase_t            phase
);

  localparam int CNT_W = $clog2(ADDR_BITS);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);

  phase_t              phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CMD_BITS-2:0] cmd_q;
  logic [MEM_AW-1:0]   addr_q;
  logic [MEM_AW-1:0]   cur_q;
  logic                fast_q;
  logic [2:0]          bidx_q;

  logic [CMD_BITS-1:0] cmd_full;
  logic [MEM_AW-1:0]   addr_full;
  logic                start_rd;
  logic                step_rd;

  // Shifting only MEM_AW bits lets the upper address bits fall off the end.
  assign cmd_full  = {cmd_q, sdi};
  assign addr_full = {addr_q[MEM_AW-2:0], sdi};

  assign start_rd = sel && rise && (phase_q == PH_ADDR) && (cnt_q == ADDR_LAST);
  assign drive    = sel && fall && (phase_q == PH_DATA);
  assign step_rd  = drive && (bidx_q == 3'd7);
  assign rd_en    = start_rd | step_rd;
  assign rd_addr  = start_rd ? addr_full : cur_q + 1'b1;
  assign bit_idx  = bidx_q;
  assign phase    = phase_q;

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      cur_q   <= '0;
      fast_q  <= 1'b0;
      bidx_q  <= '0;
    end else begin
      if (rise) begin
        unique case (phase_q)
          PH_CMD: begin
            cmd_q <= cmd_full[CMD_BITS-2:0];
            if (cnt_q == CMD_LAST) begin
              cnt_q <= '0;
              if (busy) begin
                phase_q <= PH_IGNORE;
              end else if (cmd_full == OP_READ) begin
                phase_q <= PH_ADDR;
                fast_q  <= 1'b0;
              end else if (cmd_full == OP_FAST) begin
                phase_q <= PH_ADDR;
                fast_q  <= 1'b1;
              end else begin
                phase_q <= PH_IGNORE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_ADDR: begin
            addr_q <= addr_full;
            if (cnt_q == ADDR_LAST) begin
              cnt_q   <= '0;
              cur_q   <= addr_full;
              phase_q <= fast_q ? PH_DUMMY : PH_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_DUMMY: begin
            if (cnt_q == CMD_LAST) begin
              cnt_q   <= '0;
              phase_q <= PH_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
          end
        endcase
      end
      if (drive) begin
        bidx_q <= bidx_q + 1'b1;
        if (bidx_q == 3'd7) begin
          cur_q <= cur_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sfr_out.sv
module sfr_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       drive,
  input  logic       raw,
  input  logic [2:0] bit_idx,
  input  logic [7:0] rdata,
  output logic       sdo,
  output logic       sdo_oe
);

  logic [2:0] pick;

  assign pick = raw ? bit_idx : (3'd7 - bit_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (!sel) begin
      sdo_oe <= 1'b0;
    end else if (drive) begin
      sdo_oe <= 1'b1;
      sdo    <= rdata[pick];
    end
  end

endmodule

// File: rtl/serial_flash_reader.sv
module serial_flash_reader
  import serflash_pkg::*;
#(
  parameter int MEM_AW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              busy,
  input  logic              raw_order,
  input  logic              bd_we,
  input  logic [MEM_AW-1:0] bd_addr,
  input  logic [7:0]        bd_data,
  output logic              sdo,
  output logic              sdo_oe
);

  logic              sel;
  logic              sck_rise;
  logic              sck_fall;
  logic              sdi_s;
  logic              rd_en;
  logic [MEM_AW-1:0] rd_addr;
  logic              drive;
  logic [2:0]        bit_idx;
  phase_t            phase;
  logic [7:0]        rdata;

  sfr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sck      (sck),
    .sdi      (sdi),
    .sel      (sel),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sdi_s    (sdi_s)
  );

  sfr_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .rise    (sck_rise),
    .fall    (sck_fall),
    .sdi     (sdi_s),
    .busy    (busy),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .drive   (drive),
    .bit_idx (bit_idx),
    .phase   (phase)
  );

  sfr_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk   (clk),
    .we    (bd_we),
    .waddr (bd_addr),
    .wdata (bd_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  sfr_out u_out (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .drive   (drive),
    .raw     (raw_order),
    .bit_idx (bit_idx),
    .rdata   (rdata),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );

endmodule

// File: rtl/sfr_chk.sv
module sfr_chk
  import serflash_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sdo,
  input logic              sdo_oe,
  input phase_t            phase,
  input logic              drive,
  input logic              rd_en,
  input logic [MEM_AW-1:0] rd_addr
);

  logic [MEM_AW-1:0] last_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_rd <= '0;
    end else if (rd_en) begin
      last_rd <= rd_addr;
    end
  end

  // R11
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

  // R9
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGNORE) |-> !sdo_oe);

  // R12
  setup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CMD || phase == PH_ADDR || phase == PH_DUMMY) |-> !sdo_oe);

  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(drive) |-> $stable(sdo));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && phase == PH_DATA) |-> (rd_addr == last_rd + 1'b1));

endmodule

bind serial_flash_reader sfr_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .sdo     (sdo),
  .sdo_oe  (sdo_oe),
  .phase   (phase),
  .drive   (drive),
  .rd_en   (rd_en),
  .rd_addr (rd_addr)
);

// File: tb/serial_flash_reader_tb.sv
`timescale 1ns/1ps
module serial_flash_reader_tb;

  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 8;
  localparam int NVEC  = 9;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [23:0] addr;
    logic        raw;
    logic        bsy;
    logic [3:0]  nb;
    logic        act;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'h03, 24'h000010, 1'b0, 1'b0, 4'd3, 1'b1},
    '{8'h03, 24'h5A00F0, 1'b0, 1'b0, 4'd2, 1'b1},
    '{8'h0B, 24'h000020, 1'b0, 1'b0, 4'd3, 1'b1},
    '{8'h03, 24'h000040, 1'b1, 1'b0, 4'd2, 1'b1},
    '{8'h0B, 24'hA30077, 1'b1, 1'b0, 4'd2, 1'b1},
    '{8'h03, 24'h000010, 1'b0, 1'b1, 4'd2, 1'b0},
    '{8'h0B, 24'h000010, 1'b0, 1'b1, 4'd2, 1'b0},
    '{8'h9F, 24'h000010, 1'b0, 1'b0, 4'd2, 1'b0},
    '{8'h03, 24'h0000FE, 1'b0, 1'b0, 4'd4, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic busy = 1'b0;
  logic raw_order = 1'b0;
  logic bd_we = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [7:0] bd_data = '0;
  logic sdo;
  logic sdo_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_flash_reader #(.MEM_AW(AW)) u_dut (
    .clk (clk), .rst (rst), .cs_n (cs_n), .sck (sck), .sdi (sdi),
    .busy (busy), .raw_order (raw_order), .bd_we (bd_we),
    .bd_addr (bd_addr), .bd_data (bd_data), .sdo (sdo), .sdo_oe (sdo_oe)
  );

  function automatic logic [7:0] pattern(input int i);
    logic [7:0] v;
    v = 8'(i * 73 + 25);
    return v ^ 8'(i >> 3);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n, inout logic saw);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      half_wait();
      saw = saw | sdo_oe;
      sck = 1'b1;
      half_wait();
      sck = 1'b0;
    end
  endtask

  task automatic recv_byte(input logic raw, output logic [7:0] b, output logic oe_all, output logic oe_any);
    logic [7:0] arr;
    arr = '0;
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 0; i < 8; i++) begin
      half_wait();
      arr[7 - i] = sdo;
      oe_all = oe_all & sdo_oe;
      oe_any = oe_any | sdo_oe;
      sck = 1'b1;
      half_wait();
      sck = 1'b0;
    end
    if (raw) begin
      for (int k = 0; k < 8; k++) b[k] = arr[7 - k];
    end else begin
      b = arr;
    end
  endtask

  function automatic string label(input vec_t v, input int k);
    int a0;
    int ak;
    a0 = int'(v.addr[AW-1:0]);
    ak = (a0 + k) % DEPTH;
    if (!v.act) return v.bsy ? "R9" : "R10";
    if (ak < a0) return "R5";
    if (k > 0) return "R4";
    if (v.raw) return "R7";
    if (v.cmd == 8'h0B) return "R6";
    if (v.addr[23:AW] != '0) return "R8";
    return "R2";
  endfunction

  task automatic run_vec(input vec_t v);
    logic saw;
    logic [7:0] got;
    logic [7:0] exp;
    logic oe_all;
    logic oe_any;
    raw_order = v.raw;
    busy = v.bsy;
    cs_n = 1'b0;
    half_wait();
    saw = 1'b0;
    send_bits({24'd0, v.cmd}, 8, saw);
    send_bits({8'd0, v.addr}, 24, saw);
    if (v.cmd == 8'h0B) send_bits(32'h0, 8, saw);
    chk(!saw, "R12", {31'd0, saw}, 32'd0);
    for (int k = 0; k < int'(v.nb); k++) begin
      recv_byte(v.raw, got, oe_all, oe_any);
      exp = pattern((int'(v.addr[AW-1:0]) + k) % DEPTH);
      if (v.act) chk(oe_all && got == exp, label(v, k), {23'd0, oe_all, got}, {23'd1, exp});
      else chk(!oe_any, label(v, k), {31'd0, oe_any}, 32'd0);
    end
    cs_n = 1'b1;
    busy = 1'b0;
    half_wait();
    half_wait();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic saw;
    logic s1;
    logic s2;
    logic [7:0] got;
    logic oe_all;
    logic oe_any;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(sdo_oe == 1'b0 && sdo == 1'b0, "R1", {30'd0, sdo_oe, sdo}, 32'd0);

    for (int i = 0; i < DEPTH; i++) begin
      bd_we = 1'b1;
      bd_addr = AW'(i);
      bd_data = pattern(i);
      @(negedge clk);
    end
    bd_we = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R3 and R11: bit held across rising edge, then abort mid-byte
    raw_order = 1'b0;
    cs_n = 1'b0;
    half_wait();
    saw = 1'b0;
    send_bits(32'h03, 8, saw);
    send_bits(32'h000030, 24, saw);
    half_wait();
    s1 = sdo;
    sck = 1'b1;
    repeat (HALF - 1) @(negedge clk);
    s2 = sdo;
    chk(s1 == s2 && s1 == pattern(8'h30)[7] && sdo_oe, "R3",
        {29'd0, sdo_oe, s1, s2}, {29'd1, pattern(8'h30)[7], pattern(8'h30)[7]});
    @(negedge clk);
    sck = 1'b0;
    half_wait();
    sck = 1'b1;
    half_wait();
    sck = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sdo_oe, "R11", {31'd0, sdo_oe}, 32'd0);
    half_wait();

    // R11: the next selection decodes a fresh command
    cs_n = 1'b0;
    half_wait();
    send_bits(32'h03, 8, saw);
    send_bits(32'h000031, 24, saw);
    recv_byte(1'b0, got, oe_all, oe_any);
    chk(oe_all && got == pattern(8'h31), "R11", {23'd0, oe_all, got}, {23'd1, pattern(8'h31)});
    cs_n = 1'b1;
    half_wait();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule